// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt events from the physical channels of a DMA controller and folds them into a single interrupt line. Each channel can signal four kinds of event: the end of a whole linked transfer, the end of a single list node that was marked for a per-node interrupt, and two separate error kinds. A one-cycle pulse on an event input sets a sticky raw bit for that channel and class. A per-class enable mask then filters the raw bits into a masked status. A per-channel summary ORs the four masked classes together, and the interrupt output is high while any summary bit is set.

Software reaches the block through a plain memory-mapped register port. Writes happen in the cycle that `reg_wr_en` is high. Reads are combinational from `reg_addr`. The port has no stall and no handshake, so every access completes in one cycle. Register offsets, with bit i always meaning channel i:

| Offset | Content | Access |
|---|---|---|
| 0x000 | per-channel summary | read |
| 0x004 / 0x008 / 0x00C / 0x010 | masked status: transfer-done, node-done, error A, error B | read |
| 0x018 / 0x01C / 0x020 / 0x024 | enable mask for the same four classes in the same order | read/write |
| 0x600 / 0x608 / 0x610 / 0x618 | raw latched events for the same four classes in the same order | read, write-one-to-clear |
| 0x690 | channel busy | read |

The interrupt service routine reads the summary and the masked registers. It then writes the serviced bits back to the raw registers to clear them.

Top module: `dma_irq_agg`

## Requirements
- R1: A one-cycle high pulse on bit i of an event input sets raw bit i of that class at the next clock edge. The bit stays set until software clears it.
- R2: Writing to a raw register clears each bit where the write data is 1 and leaves each bit where the data is 0 unchanged.
- R3: If an event for a bit arrives in the same cycle as a write that clears that bit, the bit stays set.
- R4: The masked status of a class reads as the raw bits ANDed with that class's mask. A mask bit of 1 lets the event through and a 0 blocks it.
- R5: Mask registers read back the value last written. Bits at or above NUM_CH read as 0 in every register.
- R6: Summary bit i is the OR of the four masked bits of channel i.
- R7: `irq_o` is high exactly when at least one summary bit is set.
- R8: The busy register at 0x690 reads the current value of `chan_busy`.
- R9: Reset clears every raw bit and every mask bit, so `irq_o` is low after reset.
- R10: Writes to the summary, masked-status and busy offsets change no state. Reads from unmapped offsets return 0.
- R11: Clearing the raw bits of one class leaves the raw bits of the other classes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr_en | input | 1 | write strobe for the register port |
| reg_addr | input | 12 | byte offset of the register access |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, combinational from reg_addr |
| evt_xfer_done | input | NUM_CH | per-channel pulse: whole transfer finished |
| evt_node_done | input | NUM_CH | per-channel pulse: flagged list node finished |
| evt_err_a | input | NUM_CH | per-channel pulse: first error kind |
| evt_err_b | input | NUM_CH | per-channel pulse: second error kind |
| chan_busy | input | NUM_CH | per-channel running indication |
| irq_o | output | 1 | combined interrupt, level |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that gives the clear priority would lose the interrupt and read the bit back as 0. It clears one class while other classes hold set bits on the same channel numbers. A shared or miswired clear would wipe those bits, and the summary would drop. It raises a raw bit behind a zero mask and checks that the masked status, the summary and the interrupt all stay quiet, which catches a filter applied only at the output. It also writes ones to the read-only offsets and to bits above the channel count, and checks that nothing moves.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_AW   = 12;
  localparam int REG_DW   = 32;
  localparam int NUM_CLS  = 4;

  typedef enum logic [1:0] {
    CLS_XFER = 2'd0,
    CLS_NODE = 2'd1,
    CLS_ERRA = 2'd2,
    CLS_ERRB = 2'd3
  } evt_cls_e;

  localparam logic [REG_AW-1:0] OFS_SUMMARY = 12'h000;
  localparam logic [REG_AW-1:0] OFS_MASKED0 = 12'h004;
  localparam logic [REG_AW-1:0] OFS_ENABLE0 = 12'h018;
  localparam logic [REG_AW-1:0] OFS_RAW0    = 12'h600;
  localparam logic [REG_AW-1:0] OFS_BUSY    = 12'h690;

  function automatic logic [REG_AW-1:0] masked_ofs(input int k);
    return OFS_MASKED0 + REG_AW'(k * 4);
  endfunction

  function automatic logic [REG_AW-1:0] enable_ofs(input int k);
    return OFS_ENABLE0 + REG_AW'(k * 4);
  endfunction

  function automatic logic [REG_AW-1:0] raw_ofs(input int k);
    return OFS_RAW0 + REG_AW'(k * 8);
  endfunction
endpackage

// File: rtl/dma_irq_class_bank.sv
module dma_irq_class_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_in,
  input  logic [NUM_CH-1:0] clr_vec,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] en_wdata,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] masked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | evt_in;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign masked = raw_q & en_q;

  // R1 and R3: an arriving event is always captured, clear or not
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((raw_q & $past(evt_in)) == $past(evt_in)));

  // R2: a cleared bit without a concurrent event drops
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((raw_q & $past(clr_vec) & ~$past(evt_in)) == '0));

  // R1: bits not being cleared are held
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ($past(raw_q) & ~$past(clr_vec))) == ($past(raw_q) & ~$past(clr_vec))));

  // R5: the mask only moves on its own write
  a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/dma_irq_regport.sv
module dma_irq_regport
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                            wr_en,
  input  logic [REG_AW-1:0]               addr,
  input  logic [REG_DW-1:0]               wdata,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  raw,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  en,
  input  logic [NUM_CLS-1:0][NUM_CH-1:0]  masked,
  input  logic [NUM_CH-1:0]               summary,
  input  logic [NUM_CH-1:0]               busy,
  output logic [NUM_CLS-1:0][NUM_CH-1:0]  clr_vec,
  output logic [NUM_CLS-1:0]              en_we,
  output logic [REG_DW-1:0]               rdata
);
  logic [NUM_CLS-1:0][NUM_CH-1:0] masked_sel, en_sel, raw_sel;
  logic [NUM_CLS-1:0]             hit_masked, hit_en, hit_raw;
  logic [NUM_CH-1:0]              rd_vec;

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    assign hit_masked[k] = (addr == masked_ofs(k));
    assign hit_en[k]     = (addr == enable_ofs(k));
    assign hit_raw[k]    = (addr == raw_ofs(k));
    assign en_we[k]      = wr_en && hit_en[k];
    assign clr_vec[k]    = (wr_en && hit_raw[k]) ? wdata[NUM_CH-1:0] : '0;
    assign masked_sel[k] = hit_masked[k] ? masked[k] : '0;
    assign en_sel[k]     = hit_en[k]     ? en[k]     : '0;
    assign raw_sel[k]    = hit_raw[k]    ? raw[k]    : '0;
  end

  always_comb begin
    rd_vec = '0;
    if (addr == OFS_SUMMARY) rd_vec = summary;
    if (addr == OFS_BUSY)    rd_vec = busy;
    for (int k = 0; k < NUM_CLS; k++)
      rd_vec = rd_vec | masked_sel[k] | en_sel[k] | raw_sel[k];
    rdata = '0;
    rdata[NUM_CH-1:0] = rd_vec;
  end

  // R8: busy offset returns the live input
  always_comb begin
    if (addr == OFS_BUSY)
      a_r8_busy_read: assert (rdata[NUM_CH-1:0] == busy);
  end
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CLS-1:0][NUM_CH-1:0] masked,
  output logic [NUM_CH-1:0]              summary,
  output logic                           irq
);
  always_comb begin
    summary = '0;
    for (int k = 0; k < NUM_CLS; k++) summary = summary | masked[k];
  end
  assign irq = |summary;
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] evt_xfer_done,
  input  logic [NUM_CH-1:0] evt_node_done,
  input  logic [NUM_CH-1:0] evt_err_a,
  input  logic [NUM_CH-1:0] evt_err_b,
  input  logic [NUM_CH-1:0] chan_busy,
  output logic              irq_o
);
  logic [NUM_CLS-1:0][NUM_CH-1:0] evt_bus, raw, en, masked, clr_vec;
  logic [NUM_CLS-1:0]             en_we;
  logic [NUM_CH-1:0]              summary;

  assign evt_bus[CLS_XFER] = evt_xfer_done;
  assign evt_bus[CLS_NODE] = evt_node_done;
  assign evt_bus[CLS_ERRA] = evt_err_a;
  assign evt_bus[CLS_ERRB] = evt_err_b;

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_bank
    dma_irq_class_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_bus[k]),
      .clr_vec  (clr_vec[k]),
      .en_we    (en_we[k]),
      .en_wdata (reg_wdata[NUM_CH-1:0]),
      .raw_q    (raw[k]),
      .en_q     (en[k]),
      .masked   (masked[k])
    );
  end

  dma_irq_combine #(.NUM_CH(NUM_CH)) u_combine (
    .masked  (masked),
    .summary (summary),
    .irq     (irq_o)
  );

  dma_irq_regport #(.NUM_CH(NUM_CH)) u_regport (
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .raw     (raw),
    .en      (en),
    .masked  (masked),
    .summary (summary),
    .busy    (chan_busy),
    .clr_vec (clr_vec),
    .en_we   (en_we),
    .rdata   (reg_rdata)
  );

  // R7: a nonzero summary read implies the interrupt is raised
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == OFS_SUMMARY) && (reg_rdata != '0)) |-> irq_o);

  // R9: first cycle out of reset has a quiet interrupt line
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_o);

  // R5: bits above the channel count never read as set
  if (NUM_CH < REG_DW) begin : g_upper
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_DW-1:NUM_CH] == '0);
  end
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0][NCH-1:0] evt = '0;
  logic [NCH-1:0] busy = '0;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_agg #(.NUM_CH(NCH)) u_dma_irq_agg (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata),
    .evt_xfer_done(evt[0]), .evt_node_done(evt[1]),
    .evt_err_a(evt[2]), .evt_err_b(evt[3]),
    .chan_busy(busy), .irq_o(irq));

  function automatic logic [11:0] a_masked(int k); return 12'h004 + 12'(4*k); endfunction
  function automatic logic [11:0] a_en(int k);     return 12'h018 + 12'(4*k); endfunction
  function automatic logic [11:0] a_raw(int k);    return 12'h600 + 12'(8*k); endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic pulse(int k, logic [NCH-1:0] v);
    @(negedge clk); evt[k] = v;
    @(negedge clk); evt[k] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      rd(a_raw(k), d); check("R9 raw after reset", d, 0);
      rd(a_en(k), d);  check("R9 mask after reset", d, 0);
    end
    check("R9 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr(a_en(0), 32'hFFFF_0008);
    rd(a_en(0), d); check("R5 mask readback upper zero", d, 32'h0000_0008);
    wr(a_en(1), 32'h0000_0002);
    wr(a_en(2), 32'h0000_0080);
    wr(a_en(3), 32'h0000_8000);
    rd(a_en(3), d); check("R5 mask readback class3", d, 32'h0000_8000);
  endtask

  task automatic t_latch_and_mask();
    logic [31:0] d;
    pulse(0, 16'h0020);
    rd(a_raw(0), d);    check("R1 raw latched", d, 32'h0020);
    rd(a_masked(0), d); check("R4 blocked by mask", d, 0);
    check("R7 irq low when masked off", {31'd0, irq}, 0);
    pulse(0, 16'h0008);
    repeat (3) @(negedge clk);
    rd(a_raw(0), d);    check("R1 raw held", d, 32'h0028);
    rd(a_masked(0), d); check("R4 masked passes", d, 32'h0008);
    check("R7 irq high", {31'd0, irq}, 1);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    pulse(1, 16'h0003);
    pulse(2, 16'h0080);
    pulse(3, 16'h8000);
    rd(a_masked(1), d); check("R4 node masked", d, 32'h0002);
    rd(12'h000, d);     check("R6 summary OR", d, 32'h808A);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(a_raw(0), 32'h0);
    rd(a_raw(0), d); check("R2 zero write keeps", d, 32'h0028);
    wr(a_raw(0), 32'h0008);
    rd(a_raw(0), d); check("R2 w1c clears bit3 only", d, 32'h0020);
    rd(a_raw(1), d); check("R11 other class intact", d, 32'h0003);
    rd(12'h000, d);  check("R6 summary after clear", d, 32'h8082);
    wr(a_raw(1), 32'hFFFF); wr(a_raw(2), 32'hFFFF);
    wr(a_raw(3), 32'hFFFF);
    rd(a_raw(3), d); check("R2 class3 cleared", d, 0);
    rd(a_raw(0), d); check("R11 class0 untouched", d, 32'h0020);
    check("R7 irq low after clears", {31'd0, irq}, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pulse(0, 16'h0004);
    @(negedge clk);
    wr_en = 1'b1; addr = a_raw(0); wdata = 32'h0004; evt[0] = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; evt[0] = '0;
    rd(a_raw(0), d); check("R3 event beats clear", d, 32'h0024);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    @(negedge clk); busy = 16'hA5C3;
    rd(12'h690, d); check("R8 busy read", d, 32'hA5C3);
    busy = 16'h0001;
    rd(12'h690, d); check("R8 busy follows", d, 32'h0001);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(12'h000, 32'hFFFF_FFFF);
    wr(a_masked(0), 32'hFFFF_FFFF);
    wr(12'h690, 32'hFFFF_FFFF);
    rd(a_raw(0), d);  check("R10 raw unchanged", d, 32'h0024);
    rd(a_en(0), d);   check("R10 mask unchanged", d, 32'h0008);
    rd(12'h100, d);   check("R10 unmapped reads zero", d, 0);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    wr(a_en(2), 32'hFFFF);
    pulse(2, 16'h0100);
    check("R7 irq before reset", {31'd0, irq}, 1);
    do_reset();
    rd(a_raw(2), d); check("R9 raw cleared by reset", d, 0);
    rd(a_en(2), d);  check("R9 mask cleared by reset", d, 0);
    check("R9 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_mask_rw();
    t_latch_and_mask();
    t_summary();
    t_clear();
    t_collision();
    t_busy();
    t_readonly();
    t_reset_again();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule